// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block takes one asynchronous serial line, optionally inverted, and turns each frame on it into a parallel word. While idle it watches for the leading edge of a start bit. That is a falling edge on a normal line and a rising edge on an inverted one. The edge marks the frame origin. From that point the block samples every bit slot at its centre. The slot width is an integer number of clock cycles set by a clocks-per-bit input.

A frame has these slots in order: a start bit, which is checked again at its centre, then 5 to 9 data bits, then an optional parity bit, then one stop bit. Data bits are assembled least-significant-first or most-significant-first. The parity bit can be checked as odd or even, or as a fixed mark (1) or space (0) value. The block reports results with single-cycle strobes: one for a finished word, one for a framing fault and one for a parity fault. The configuration inputs are captured only while the receiver is idle, so changing them in the middle of a frame does not disturb that frame.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset `data_out`, `data_valid`, `frame_err` and `parity_err` are all zero, and the receiver waits for a start edge.
- R2: In idle, a falling edge of the normalised line starts a frame. Slot n is sampled `half + n*cpb` cycles after the edge, where cpb is the clocks-per-bit value (at least 4) and half is (cpb-1)/2 with integer division. Back-to-back frames are received when the next start edge follows the stop-slot sample.
- R3: If the start slot samples 1 at its centre, the receiver pulses `frame_err`, returns to idle and gives no `data_valid`. A low glitch shorter than half a bit is therefore rejected.
- R4: `cfg_word_len` selects 5, 6, 7, 8 or 9 data bits. Values below 5 act as 5 and values above 9 act as 9. `data_out` is right-aligned and its unused upper bits are zero.
- R5: With `cfg_msb_first`=0, the first data bit received becomes bit 0 of the word.
- R6: With `cfg_msb_first`=1, the first data bit received becomes bit N-1 of the word.
- R7: `cfg_parity` encoding: 0 none, 1 odd, 2 even, 3 space, 4 mark. For odd (even) parity, `parity_err` pulses when the number of ones in the data bits plus the parity bit is even (odd).
- R8: For space (mark) parity, `parity_err` pulses when the parity bit is not 0 (1).
- R9: With `cfg_parity_check`=0, `parity_err` never pulses, but the parity slot is still consumed and the word is still delivered. With parity none, the stop slot follows the last data bit directly.
- R10: A stop slot sampled as 0 pulses `frame_err`. The word has already been delivered, and the receiver returns to idle either way.
- R11: `data_valid` is high for exactly one cycle per received word, on the cycle after the last data bit is sampled.
- R12: With `cfg_invert`=1, the line is complemented before edge detection and sampling.
- R13: Configuration inputs that change while a frame is in progress have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input |
| cfg_clks_per_bit | input | 16 | Bit period in clock cycles (minimum 4) |
| cfg_word_len | input | 4 | Number of data bits, 5 to 9 |
| cfg_parity | input | 3 | Parity mode: 0 none, 1 odd, 2 even, 3 space, 4 mark |
| cfg_parity_check | input | 1 | Enables the parity error strobe |
| cfg_msb_first | input | 1 | 1: first data bit is the MSB |
| cfg_invert | input | 1 | 1: line is inverted |
| data_out | output | 9 | Last received word, right-aligned |
| data_valid | output | 1 | One-cycle strobe for a new word |
| frame_err | output | 1 | One-cycle strobe for a bad start or stop bit |
| parity_err | output | 1 | One-cycle strobe for a parity mismatch |

## Verification
Two events meet in one cycle when the stop slot is sampled: the receiver returns to idle, and the edge detector must be armed for the next start. To provoke this, a frame is sent whose stop bit is held only a little past its centre, and the next start bit follows at once. The check is that both words arrive, with the right values, and that no frame error is raised. A second kind of coincidence comes from configuration inputs that change during a frame. It is judged by the word that comes out, which must match the configuration in force when the frame began.

// File: rtl/uart_frame_rx_pkg.sv
package uart_frame_rx_pkg;

    localparam int WORD_MAX = 9;
    localparam int LEN_W    = 4;
    localparam int CPB_W    = 16;
    localparam int CPB_MIN  = 4;
    localparam int LEN_MIN  = 5;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_SPACE = 3'd3,
        PAR_MARK  = 3'd4
    } parity_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CPB_W-1:0] cpb;
        logic [LEN_W-1:0] nbits;
        parity_mode_e     parity;
        logic             check;
        logic             msb_first;
        logic             invert;
    } rx_cfg_t;

    // True when the received parity bit agrees with the mode.
    // data_ones_odd is the XOR of all received data bits.
    function automatic logic parity_good(parity_mode_e mode, logic pbit,
                                         logic data_ones_odd);
        case (mode)
            PAR_ODD:   return (data_ones_odd ^ pbit) == 1'b1;
            PAR_EVEN:  return (data_ones_odd ^ pbit) == 1'b0;
            PAR_SPACE: return pbit == 1'b0;
            PAR_MARK:  return pbit == 1'b1;
            default:   return 1'b1;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(logic [LEN_W-1:0] raw);
        if (raw < LEN_W'(LEN_MIN))  return LEN_W'(LEN_MIN);
        if (raw > LEN_W'(WORD_MAX)) return LEN_W'(WORD_MAX);
        return raw;
    endfunction

    function automatic logic [CPB_W-1:0] clamp_cpb(logic [CPB_W-1:0] raw);
        if (raw < CPB_W'(CPB_MIN)) return CPB_W'(CPB_MIN);
        return raw;
    endfunction

    function automatic parity_mode_e clamp_par(logic [2:0] raw);
        if (raw > 3'd4) return PAR_NONE;
        return parity_mode_e'(raw);
    endfunction

endpackage

// File: rtl/uart_rx_frontend.sv
module uart_rx_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic invert,
    output logic line_n,
    output logic start_edge
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= line_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign line_n = sync_q[SYNC_STAGES-1] ^ invert;

    // prev resets to 0 so that the first cycles after reset never look
    // like a falling edge, whatever the polarity.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= line_n;
    end

    assign start_edge = prev_q & ~line_n;
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer
    import uart_frame_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [CPB_W-1:0] cpb,
    output logic             tick
);
    logic [CPB_W-1:0] cnt_q;
    logic [CPB_W-1:0] half_m1;

    // The first sample lands (cpb-1)/2 cycles after the edge cycle.
    // Loading happens in the edge cycle, so the count starts one lower.
    assign half_m1 = ((cpb - CPB_W'(1)) >> 1) - CPB_W'(1);
    assign tick    = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= half_m1;
        else if (run) begin
            if (cnt_q == '0) cnt_q <= cpb - CPB_W'(1);
            else             cnt_q <= cnt_q - CPB_W'(1);
        end
    end
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
    import uart_frame_rx_pkg::*;
(
    input  logic [WORD_MAX-1:0] word_in,
    input  logic                bit_in,
    input  logic [LEN_W-1:0]    nbits,
    input  logic                msb_first,
    output logic [WORD_MAX-1:0] word_out
);
    logic [WORD_MAX-1:0] mask;
    logic [WORD_MAX-1:0] lsb_word;
    logic [WORD_MAX-1:0] msb_word;

    always_comb begin
        lsb_word = word_in >> 1;
        for (int i = 0; i < WORD_MAX; i++) begin
            mask[i] = (i < int'(nbits));
            if (i == int'(nbits) - 1) lsb_word[i] = bit_in;
        end
        msb_word = {word_in[WORD_MAX-2:0], bit_in} & mask;
        word_out = msb_first ? msb_word : (lsb_word & mask);
    end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_frame_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    input  logic [CPB_W-1:0]     cfg_clks_per_bit,
    input  logic [LEN_W-1:0]     cfg_word_len,
    input  logic [2:0]           cfg_parity,
    input  logic                 cfg_parity_check,
    input  logic                 cfg_msb_first,
    input  logic                 cfg_invert,
    output logic [WORD_MAX-1:0]  data_out,
    output logic                 data_valid,
    output logic                 frame_err,
    output logic                 parity_err
);
    rx_state_e           state;
    rx_cfg_t             cfg_q;
    logic [LEN_W-1:0]    bit_idx;
    logic [WORD_MAX-1:0] word_q;
    logic [WORD_MAX-1:0] word_nxt;
    logic                ones_odd;
    logic                line_n;
    logic                start_edge;
    logic                tick;

    uart_rx_frontend #(.SYNC_STAGES(2)) u_front (
        .clk        (clk),
        .rst        (rst),
        .line_in    (rx_line),
        .invert     (cfg_q.invert),
        .line_n     (line_n),
        .start_edge (start_edge)
    );

    uart_rx_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (state == ST_IDLE && start_edge),
        .run  (state != ST_IDLE),
        .cpb  (cfg_q.cpb),
        .tick (tick)
    );

    uart_rx_shift u_shift (
        .word_in   (word_q),
        .bit_in    (line_n),
        .nbits     (cfg_q.nbits),
        .msb_first (cfg_q.msb_first),
        .word_out  (word_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cfg_q      <= '{cpb: CPB_W'(CPB_MIN), nbits: LEN_W'(8), parity: PAR_NONE,
                            check: 1'b0, msb_first: 1'b0, invert: 1'b0};
            bit_idx    <= '0;
            word_q     <= '0;
            ones_odd   <= 1'b0;
            data_out   <= '0;
            data_valid <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            data_valid <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cfg_q.cpb       <= clamp_cpb(cfg_clks_per_bit);
                    cfg_q.nbits     <= clamp_len(cfg_word_len);
                    cfg_q.parity    <= clamp_par(cfg_parity);
                    cfg_q.check     <= cfg_parity_check;
                    cfg_q.msb_first <= cfg_msb_first;
                    cfg_q.invert    <= cfg_invert;
                    if (start_edge) state <= ST_START;
                end
                ST_START: if (tick) begin
                    if (line_n) begin
                        frame_err <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        bit_idx  <= '0;
                        word_q   <= '0;
                        ones_odd <= 1'b0;
                        state    <= ST_DATA;
                    end
                end
                ST_DATA: if (tick) begin
                    word_q   <= word_nxt;
                    ones_odd <= ones_odd ^ line_n;
                    if (bit_idx == cfg_q.nbits - LEN_W'(1)) begin
                        data_out   <= word_nxt;
                        data_valid <= 1'b1;
                        state      <= (cfg_q.parity == PAR_NONE) ? ST_STOP : ST_PARITY;
                    end else begin
                        bit_idx <= bit_idx + LEN_W'(1);
                    end
                end
                ST_PARITY: if (tick) begin
                    if (cfg_q.check && !parity_good(cfg_q.parity, line_n, ones_odd))
                        parity_err <= 1'b1;
                    state <= ST_STOP;
                end
                ST_STOP: if (tick) begin
                    if (!line_n) frame_err <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_frame_rx_checker.sv
module uart_frame_rx_checker
    import uart_frame_rx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input rx_state_e           state,
    input rx_cfg_t             cfg_q,
    input logic [WORD_MAX-1:0] data_out,
    input logic                data_valid,
    input logic                frame_err,
    input logic                parity_err
);
    assert_valid_single_R11: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> !data_valid);

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> ((data_out >> cfg_q.nbits) == '0));

    assert_no_word_on_bad_start_R3: assert property (@(posedge clk) disable iff (rst)
        !(frame_err && data_valid));

    assert_perr_gated_R9: assert property (@(posedge clk) disable iff (rst)
        parity_err |-> (cfg_q.check && cfg_q.parity != PAR_NONE));

    assert_ferr_slot_R10: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> ($past(state) == ST_START || $past(state) == ST_STOP));

    assert_cfg_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(cfg_q));
endmodule

bind uart_frame_rx uart_frame_rx_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .cfg_q      (cfg_q),
    .data_out   (data_out),
    .data_valid (data_valid),
    .frame_err  (frame_err),
    .parity_err (parity_err)
);

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
    localparam int CPB  = 10;
    localparam int HALF = (CPB - 1) / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic [15:0] cfg_clks_per_bit = 16'(CPB);
    logic [3:0]  cfg_word_len = 4'd8;
    logic [2:0]  cfg_parity = 3'd0;
    logic        cfg_parity_check = 1'b1;
    logic        cfg_msb_first = 1'b0;
    logic        cfg_invert = 1'b0;
    logic [8:0]  data_out;
    logic        data_valid, frame_err, parity_err;

    int n_checks = 0;
    int n_errors = 0;
    int n_dv = 0, n_fe = 0, n_pe = 0;
    logic [8:0] first_data = '0, last_data = '0;

    always #10 clk = ~clk;

    uart_frame_rx u_uart_frame_rx (
        .clk(clk), .rst(rst), .rx_line(rx_line),
        .cfg_clks_per_bit(cfg_clks_per_bit), .cfg_word_len(cfg_word_len),
        .cfg_parity(cfg_parity), .cfg_parity_check(cfg_parity_check),
        .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
        .data_out(data_out), .data_valid(data_valid),
        .frame_err(frame_err), .parity_err(parity_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (data_valid) begin
                if (n_dv == 0) first_data = data_out;
                last_data = data_out;
                n_dv++;
            end
            if (frame_err)  n_fe++;
            if (parity_err) n_pe++;
        end
    end

    typedef struct packed {
        logic [3:0] nb;
        logic [2:0] par;
        logic       msb;
        logic       inv;
        logic       chk;
        logic [8:0] val;
        logic       flip;
        logic       stopv;
    } vec_t;

    // nb, parity, msb_first, invert, check, value, corrupt parity, stop level
    localparam vec_t VECS [12] = '{
        '{4'd8, 3'd0, 1'b0, 1'b0, 1'b1, 9'h0A5, 1'b0, 1'b1},  // R2 R5
        '{4'd8, 3'd0, 1'b1, 1'b0, 1'b1, 9'h03C, 1'b0, 1'b1},  // R6
        '{4'd5, 3'd0, 1'b0, 1'b0, 1'b1, 9'h01B, 1'b0, 1'b1},  // R4
        '{4'd9, 3'd2, 1'b0, 1'b0, 1'b1, 9'h1F3, 1'b0, 1'b1},  // R4 R7
        '{4'd7, 3'd1, 1'b1, 1'b0, 1'b1, 9'h055, 1'b1, 1'b1},  // R7 odd, bad
        '{4'd6, 3'd2, 1'b0, 1'b0, 1'b1, 9'h02A, 1'b1, 1'b1},  // R7 even, bad
        '{4'd8, 3'd3, 1'b0, 1'b0, 1'b1, 9'h081, 1'b0, 1'b1},  // R8 space, good
        '{4'd8, 3'd4, 1'b0, 1'b0, 1'b1, 9'h07E, 1'b1, 1'b1},  // R8 mark, bad
        '{4'd8, 3'd1, 1'b0, 1'b0, 1'b0, 9'h033, 1'b1, 1'b1},  // R9 check off
        '{4'd8, 3'd0, 1'b0, 1'b1, 1'b1, 9'h0C3, 1'b0, 1'b1},  // R12
        '{4'd9, 3'd4, 1'b1, 1'b1, 1'b1, 9'h101, 1'b0, 1'b1},  // R12 R8 R6
        '{4'd8, 3'd0, 1'b0, 1'b0, 1'b1, 9'h05A, 1'b0, 1'b0}   // R10
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int cycles);
        rx_line = lvl;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic configure(input int nb, input int par, input logic msb,
                             input logic inv, input logic chk);
        cfg_word_len = 4'(nb); cfg_parity = 3'(par); cfg_msb_first = msb;
        cfg_invert = inv; cfg_parity_check = chk;
        rx_line = ~inv;
        repeat (3 * CPB) @(negedge clk);
        n_dv = 0; n_fe = 0; n_pe = 0;
    endtask

    task automatic send(input int nb, input int par, input logic msb, input logic inv,
                        input logic [8:0] val, input logic flip, input logic stopv,
                        input int stop_len);
        logic p;
        p = 1'b0;
        drive(1'b0 ^ inv, CPB);
        for (int i = 0; i < nb; i++) begin
            logic b;
            b = msb ? val[nb-1-i] : val[i];
            p ^= b;
            drive(b ^ inv, CPB);
        end
        if (par != 0) begin
            logic pb;
            case (par)
                1: pb = ~p;
                2: pb = p;
                3: pb = 1'b0;
                default: pb = 1'b1;
            endcase
            drive((pb ^ flip) ^ inv, CPB);
        end
        drive(stopv ^ inv, stop_len);
        rx_line = ~inv;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(data_out == 9'h0 && !data_valid && !frame_err && !parity_err,
              "R1 reset outputs", int'({data_out, data_valid, frame_err, parity_err}), 0);

        foreach (VECS[k]) begin
            vec_t v;
            int   m;
            v = VECS[k];
            m = (1 << v.nb) - 1;
            configure(v.nb, v.par, v.msb, v.inv, v.chk);
            send(v.nb, v.par, v.msb, v.inv, v.val, v.flip, v.stopv, CPB);
            repeat (3 * CPB) @(negedge clk);
            check(n_dv == 1, "R11 one data_valid cycle", n_dv, 1);
            check(last_data == 9'(m & int'(v.val)), "R2 R4 R5 R6 R12 word", last_data, m & int'(v.val));
            check(n_pe == ((v.flip && v.chk && v.par != 0) ? 1 : 0), "R7 R8 R9 parity flag",
                  n_pe, (v.flip && v.chk && v.par != 0) ? 1 : 0);
            check(n_fe == (v.stopv ? 0 : 1), "R10 frame flag", n_fe, v.stopv ? 0 : 1);
        end

        // R3: low glitch shorter than half a bit
        configure(8, 0, 1'b0, 1'b0, 1'b1);
        drive(1'b0, HALF - 1);
        drive(1'b1, 3 * CPB);
        check(n_fe == 1, "R3 glitch frame_err", n_fe, 1);
        check(n_dv == 0, "R3 glitch no word", n_dv, 0);

        // R13: configuration changed mid-frame has no effect
        configure(8, 0, 1'b0, 1'b0, 1'b1);
        fork
            send(8, 0, 1'b0, 1'b0, 9'h096, 1'b0, 1'b1, CPB);
            begin
                repeat (3 * CPB) @(negedge clk);
                cfg_word_len = 4'd5; cfg_msb_first = 1'b1; cfg_parity = 3'd1;
            end
        join
        repeat (3 * CPB) @(negedge clk);
        check(n_dv == 1 && last_data == 9'h096, "R13 mid-frame cfg change", last_data, 9'h096);
        check(n_pe == 0 && n_fe == 0, "R13 no flags", n_pe + n_fe, 0);

        // R2: back-to-back frames, stop held just past its centre
        configure(8, 0, 1'b0, 1'b0, 1'b1);
        send(8, 0, 1'b0, 1'b0, 9'h011, 1'b0, 1'b1, HALF + 2);
        send(8, 0, 1'b0, 1'b0, 9'h022, 1'b0, 1'b1, CPB);
        repeat (3 * CPB) @(negedge clk);
        check(n_dv == 2, "R2 back-to-back count", n_dv, 2);
        check(first_data == 9'h011, "R2 back-to-back first", first_data, 9'h011);
        check(last_data == 9'h022, "R2 back-to-back second", last_data, 9'h022);
        check(n_fe == 0, "R2 back-to-back no frame_err", n_fe, 0);

        // R4: out-of-range length clamps to 9
        configure(15, 0, 1'b0, 1'b0, 1'b1);
        send(9, 0, 1'b0, 1'b0, 9'h1AB, 1'b0, 1'b1, CPB);
        repeat (3 * CPB) @(negedge clk);
        check(n_dv == 1 && last_data == 9'h1AB, "R4 length clamp", last_data, 9'h1AB);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule